// File: doc/BRIEF.md
# Page List Address Generator

This block turns the data-pointer fields of a storage command into an ordered stream of memory segments for a data-movement engine. Each segment is a start address and a byte count. The command supplies three 64-bit page pointers and a transfer length in bytes. The first pointer may start anywhere inside its page. Every later pointer must be page aligned. Every segment between the first and the final one covers a whole page, and the final segment covers whatever remains.

Short transfers are described entirely by the inline pointers. When the bytes left after the first segment fit into two pages, the second and third pointers are data pages. When more bytes are left, the second pointer is still a data page, but the third pointer becomes the base of a single page-sized list of further page pointers. The block reads that list one 8-byte entry at a time through a request/response port, and it emits a segment for each entry before it asks for the next one.

A non-first pointer with any page-offset bit set is treated as corrupt. The block reports it with a single-cycle error pulse, emits no segment for that pointer and returns to idle.

Top module: `page_list_agen`

## Requirements
- R1: The first segment of a command starts at the first pointer, and its byte count is the smaller of (page size minus the first pointer's low page-offset bits) and the transfer length.
- R2: Every segment after the first and before the final one is exactly one page long. The final segment carries the bytes still owed. Across a command, the byte counts add up to the transfer length.
- R3: `seg_last` is 1 on the final segment of a command and 0 on every other segment.
- R4: When the bytes left after the first segment are at most one page, the second segment comes from the second pointer and no read request is issued.
- R5: When the bytes left after the first segment are more than one page but at most two pages, the second and third pointers are used in that order as data pages and no read request is issued.
- R6: When the bytes left after the first segment exceed two pages, the second pointer supplies the second segment. The third pointer is then used as a list base, and list entry i is requested at address base + 8*i, with i rising from 0. Only one read is outstanding at a time, and the request address is held until the request is accepted.
- R7: A non-first pointer whose page-offset bits are not all zero (whether inline or read from the list) produces a one-cycle `err` pulse. No segment is emitted for that pointer, and the block is back in idle (`cmd_ready` = 1) in the same cycle as the pulse.
- R8: `cmd_ready` is 1 only while idle. It stays 0 from the acceptance of a command until its final segment has been taken or an error has ended it.
- R9: While `seg_valid` is 1 and `seg_ready` is 0, the segment address, byte count and last flag hold steady and `seg_valid` stays 1.
- R10: After reset the block is idle: `cmd_ready` = 1, and `seg_valid`, `rd_req_valid` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_ptr1 | input | ADDR_W | First data pointer, may carry a page offset |
| cmd_ptr2 | input | ADDR_W | Second data pointer, page aligned |
| cmd_ptr3 | input | ADDR_W | Third data pointer or list base |
| cmd_len | input | LEN_W | Transfer length in bytes, nonzero |
| seg_valid | output | 1 | A segment is offered |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_bytes | output | LEN_W | Segment byte count |
| seg_last | output | 1 | Final segment of the command |
| rd_req_valid | output | 1 | List-entry read requested |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Address of the list entry |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | ADDR_W | The list entry (a page pointer) |
| err | output | 1 | One-cycle pulse on a misaligned non-first pointer |

## Verification
The assertions assume the following about the inputs:
- `cmd_len` is nonzero.
- The length never needs more list entries than one list page holds.
- Memory returns exactly one response per accepted request, and only after accepting it.

The bench keeps within these limits. It caps each length at the capacity for the chosen first-page offset, which is the page remainder plus one page plus a full list page. It sends one response one cycle after each accepted request. The bench also throttles `seg_ready` in a fixed pattern, so that the hold rule is exercised on nearly every command.

// File: rtl/plna_pkg.sv
package plna_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EMIT,
      ST_PICK,
      ST_REQ,
      ST_WAIT
   } plna_state_e;
endpackage

// File: rtl/plna_seg_math.sv
module plna_seg_math #(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 32,
   parameter int PAGE_BYTES = 4096
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [LEN_W-1:0]  rem,
   input  logic              first,
   output logic [LEN_W-1:0]  bytes,
   output logic              misaligned
);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam logic [PW:0] PAGE_V = (PW+1)'(PAGE_BYTES);

   logic [PW-1:0] off;
   logic [PW:0]   room;

   assign off        = ptr[PW-1:0];
   assign room       = first ? (PAGE_V - {1'b0, off}) : PAGE_V;
   assign misaligned = !first && (off != '0);

   generate
      if (LEN_W > PW) begin : g_wide_len
         logic [LEN_W-1:0] room_w;
         assign room_w = LEN_W'(room);
         assign bytes  = (rem < room_w) ? rem : room_w;
      end else begin : g_narrow_len
         logic [PW:0] rem_w;
         assign rem_w = (PW+1)'(rem);
         assign bytes = LEN_W'((rem_w < room) ? rem_w : room);
      end
   endgenerate
endmodule

// File: rtl/plna_list_addr.sv
module plna_list_addr #(
   parameter int ADDR_W      = 64,
   parameter int IDX_W       = 11,
   parameter int ENTRY_BYTES = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int EW = $clog2(ENTRY_BYTES);
   assign addr = base + (ADDR_W'(idx) << EW);
endmodule

// File: rtl/page_list_agen.sv
module page_list_agen #(
   parameter int ADDR_W      = 64,
   parameter int LEN_W       = 32,
   parameter int PAGE_BYTES  = 4096,
   parameter int ENTRY_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_ptr1,
   input  logic [ADDR_W-1:0] cmd_ptr2,
   input  logic [ADDR_W-1:0] cmd_ptr3,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [LEN_W-1:0]  seg_bytes,
   output logic              seg_last,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [ADDR_W-1:0] rd_rsp_data,
   output logic              err
);
   import plna_pkg::*;

   localparam int PW           = $clog2(PAGE_BYTES);
   localparam int LIST_ENTRIES = PAGE_BYTES / ENTRY_BYTES;
   localparam int IDX_W        = $clog2(LIST_ENTRIES) + 2;
   localparam logic [LEN_W:0] TWO_PAGES = (LEN_W+1)'(2 * PAGE_BYTES);

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 16) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 16");
      end
      if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0 || ENTRY_BYTES >= PAGE_BYTES) begin : g_bad_entry
         $error("ENTRY_BYTES must be a power of two below PAGE_BYTES");
      end
      if (ADDR_W <= PW || LEN_W <= PW) begin : g_bad_width
         $error("ADDR_W and LEN_W must exceed the page offset width");
      end
   endgenerate

   plna_state_e      state;
   logic [ADDR_W-1:0] p2_q, p3_q;
   logic [LEN_W-1:0]  rem_q;
   logic [IDX_W-1:0]  k_q;
   logic              list_mode_q;
   logic [ADDR_W-1:0] seg_addr_q;
   logic [LEN_W-1:0]  seg_bytes_q;
   logic              seg_last_q;
   logic              err_q;

   logic [ADDR_W-1:0] m_ptr;
   logic [LEN_W-1:0]  m_rem, m_bytes, m_left;
   logic              m_first, m_bad;
   logic              from_list, load_fire;
   logic [ADDR_W-1:0] list_addr;
   logic [IDX_W-1:0]  list_idx;

   assign m_first   = (state == ST_IDLE);
   assign m_rem     = m_first ? cmd_len : rem_q;
   assign from_list = list_mode_q && (k_q >= IDX_W'(2));
   assign list_idx  = k_q - IDX_W'(2);

   always_comb begin
      if (state == ST_IDLE)      m_ptr = cmd_ptr1;
      else if (state == ST_WAIT) m_ptr = rd_rsp_data;
      else if (k_q == IDX_W'(1)) m_ptr = p2_q;
      else                       m_ptr = p3_q;
   end

   always_comb begin
      unique case (state)
         ST_IDLE: load_fire = cmd_valid;
         ST_PICK: load_fire = !from_list;
         ST_WAIT: load_fire = rd_rsp_valid;
         default: load_fire = 1'b0;
      endcase
   end

   assign m_left = m_rem - m_bytes;

   plna_seg_math #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_math (
      .ptr        (m_ptr),
      .rem        (m_rem),
      .first      (m_first),
      .bytes      (m_bytes),
      .misaligned (m_bad)
   );

   plna_list_addr #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_laddr (
      .base (p3_q),
      .idx  (list_idx),
      .addr (list_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         p2_q        <= '0;
         p3_q        <= '0;
         rem_q       <= '0;
         k_q         <= '0;
         list_mode_q <= 1'b0;
         seg_addr_q  <= '0;
         seg_bytes_q <= '0;
         seg_last_q  <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (state == ST_IDLE && cmd_valid) begin
            p2_q        <= cmd_ptr2;
            p3_q        <= cmd_ptr3;
            list_mode_q <= ({1'b0, m_left} > TWO_PAGES);
         end
         if (load_fire) begin
            if (m_bad) begin
               err_q <= 1'b1;
               state <= ST_IDLE;
            end else begin
               seg_addr_q  <= m_ptr;
               seg_bytes_q <= m_bytes;
               seg_last_q  <= (m_left == '0);
               rem_q       <= m_left;
               k_q         <= m_first ? IDX_W'(1) : k_q + IDX_W'(1);
               state       <= ST_EMIT;
            end
         end else begin
            unique case (state)
               ST_EMIT: if (seg_ready) state <= seg_last_q ? ST_IDLE : ST_PICK;
               ST_PICK: if (from_list) state <= ST_REQ;
               ST_REQ:  if (rd_req_ready) state <= ST_WAIT;
               default: ;
            endcase
         end
      end
   end

   assign cmd_ready    = (state == ST_IDLE);
   assign seg_valid    = (state == ST_EMIT);
   assign seg_addr     = seg_addr_q;
   assign seg_bytes    = seg_bytes_q;
   assign seg_last     = seg_last_q;
   assign rd_req_valid = (state == ST_REQ);
   assign rd_req_addr  = list_addr;
   assign err          = err_q;
endmodule

// File: rtl/page_list_agen_chk.sv
module page_list_agen_chk #(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 32,
   parameter int PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              seg_valid,
   input logic              seg_ready,
   input logic [ADDR_W-1:0] seg_addr,
   input logic [LEN_W-1:0]  seg_bytes,
   input logic              seg_last,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_req_addr,
   input logic              rd_rsp_valid,
   input logic              err
);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

   logic in_first, pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_first <= 1'b0;
         pend     <= 1'b0;
      end else begin
         if (cmd_valid && cmd_ready)      in_first <= 1'b1;
         else if (seg_valid && seg_ready) in_first <= 1'b0;
         if (rd_req_valid && rd_req_ready) pend <= 1'b1;
         else if (rd_rsp_valid)            pend <= 1'b0;
      end
   end

   assert_first_fit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && in_first |-> seg_bytes <= PAGE_L - LEN_W'(seg_addr[PW-1:0]));

   assert_seg_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_bytes != '0) && (seg_bytes <= PAGE_L));

   assert_mid_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !in_first && !seg_last |-> seg_bytes == PAGE_L);

   assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !pend && !seg_valid);

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

   assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !in_first |-> seg_addr[PW-1:0] == '0);

   assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> cmd_ready && !seg_valid);

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid || rd_req_valid || pend |-> !cmd_ready);

   assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr)
                                  && $stable(seg_bytes) && $stable(seg_last));
endmodule

bind page_list_agen page_list_agen_chk #(
   .ADDR_W     (ADDR_W),
   .LEN_W      (LEN_W),
   .PAGE_BYTES (PAGE_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .seg_valid    (seg_valid),
   .seg_ready    (seg_ready),
   .seg_addr     (seg_addr),
   .seg_bytes    (seg_bytes),
   .seg_last     (seg_last),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .rd_req_addr  (rd_req_addr),
   .rd_rsp_valid (rd_rsp_valid),
   .err          (err)
);

// File: tb/page_list_agen_tb.sv
module page_list_agen_tb;
   localparam int AW = 64;
   localparam int LW = 16;
   localparam int PG = 64;
   localparam int EB = 8;
   localparam logic [63:0] P1_BASE   = 64'h1000_0000;
   localparam logic [63:0] P2_BASE   = 64'h2000_0040;
   localparam logic [63:0] P3_BASE   = 64'h3000_0080;
   localparam logic [63:0] LIST_BASE = 64'h4000_0100;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_ready;
   logic [AW-1:0] cmd_ptr1 = '0, cmd_ptr2 = '0, cmd_ptr3 = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          seg_valid, seg_ready = 1'b0, seg_last;
   logic [AW-1:0] seg_addr;
   logic [LW-1:0] seg_bytes;
   logic          rd_req_valid, rd_req_ready = 1'b0;
   logic [AW-1:0] rd_req_addr;
   logic          rd_rsp_valid = 1'b0;
   logic [AW-1:0] rd_rsp_data = '0;
   logic          err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   page_list_agen #(
      .ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PG), .ENTRY_BYTES(EB)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_ptr1(cmd_ptr1), .cmd_ptr2(cmd_ptr2), .cmd_ptr3(cmd_ptr3), .cmd_len(cmd_len),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_bytes(seg_bytes), .seg_last(seg_last),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .err(err)
   );

   function automatic logic [63:0] list_val(int i);
      return 64'h5000_0000 + 64'(i) * 64'(PG * 3);
   endfunction

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(input bit ok, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", what);
      end
   endtask

   // bad_k: index of the non-first entry to corrupt, 0 for none
   task automatic run_cmd(input int off, input int len, input int bad_k);
      int first_b   = imin(PG - off, len);
      int rem1      = len - first_b;
      bit use_list  = rem1 > 2 * PG;
      int n_ent     = 1 + (rem1 + PG - 1) / PG;
      bit exp_err   = (bad_k >= 1) && (bad_k < n_ent);
      logic [63:0] p1 = P1_BASE + 64'(off);
      logic [63:0] p2 = P2_BASE | ((bad_k == 1) ? 64'h4 : 64'h0);
      logic [63:0] p3 = use_list ? LIST_BASE : (P3_BASE | ((bad_k == 2) ? 64'h4 : 64'h0));
      int  k = 0, remx = len, reads = 0, rd_idx = 0, t = 0, exp_reads;
      bit  done = 0, err_seen = 0, rsp_pend = 0, hold = 0, sready;
      logic [63:0] h_addr;
      logic [LW-1:0] h_bytes;
      logic h_last;

      @(negedge clk);
      cmd_valid = 1'b1; cmd_ptr1 = p1; cmd_ptr2 = p2; cmd_ptr3 = p3; cmd_len = LW'(len);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, $sformatf("R8 busy after accept off=%0d len=%0d act=%0b exp=0",
                                       off, len, cmd_ready));
      while (!done && t < 2000) begin
         rd_req_ready = 1'b0;
         if (rsp_pend) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = list_val(rd_idx - 1) |
                           ((bad_k >= 2 && bad_k - 2 == rd_idx - 1) ? 64'h8 : 64'h0);
            rsp_pend = 0;
         end else begin
            rd_rsp_valid = 1'b0;
         end
         if (rd_req_valid) begin
            chk(rd_req_addr == LIST_BASE + 64'(EB * rd_idx),
                $sformatf("R6 list addr idx=%0d act=%h exp=%h", rd_idx, rd_req_addr,
                          LIST_BASE + 64'(EB * rd_idx)));
            rd_req_ready = 1'b1;
            rd_idx++; reads++; rsp_pend = 1;
         end
         if (err) begin
            err_seen = 1; done = 1;
         end
         if (hold) begin
            chk(seg_valid && seg_addr == h_addr && seg_bytes == h_bytes && seg_last == h_last,
                $sformatf("R9 hold act=%0b/%h/%0d/%0b exp=1/%h/%0d/%0b", seg_valid, seg_addr,
                          seg_bytes, seg_last, h_addr, h_bytes, h_last));
            hold = 0;
         end
         sready = (t % 3) != 1;
         seg_ready = sready;
         if (seg_valid) begin
            if (!sready) begin
               hold = 1; h_addr = seg_addr; h_bytes = seg_bytes; h_last = seg_last;
            end else begin
               int eb = (k == 0) ? first_b : imin(PG, remx);
               logic [63:0] ea = (k == 0) ? p1 : (k == 1) ? p2 :
                                 use_list ? list_val(k - 2) : p3;
               bit el = (remx - eb) == 0;
               chk(seg_addr == ea && int'(seg_bytes) == eb && seg_last == el,
                   $sformatf("%s R3 off=%0d len=%0d seg%0d act=%h/%0d/%0b exp=%h/%0d/%0b",
                             (k == 0) ? "R1" : "R2", off, len, k, seg_addr, seg_bytes,
                             seg_last, ea, eb, el));
               remx -= eb; k++;
               if (seg_last) done = 1;
            end
         end
         @(negedge clk);
         t++;
      end
      rd_rsp_valid = 1'b0; rd_req_ready = 1'b0; seg_ready = 1'b0;
      chk(t < 2000, $sformatf("R2 command hung off=%0d len=%0d act=%0d exp<2000", off, len, t));
      chk(err_seen == exp_err, $sformatf("R7 err off=%0d len=%0d bad=%0d act=%0b exp=%0b",
                                         off, len, bad_k, err_seen, exp_err));
      if (exp_err)
         chk(k == bad_k, $sformatf("R7 segs before err act=%0d exp=%0d", k, bad_k));
      else
         chk(remx == 0, $sformatf("R2 bytes owed off=%0d len=%0d act=%0d exp=0", off, len, remx));
      if (!use_list) exp_reads = 0;
      else if (exp_err) exp_reads = (bad_k >= 2) ? bad_k - 1 : 0;
      else exp_reads = n_ent - 2;
      chk(reads == exp_reads, $sformatf("%s reads off=%0d len=%0d act=%0d exp=%0d",
                                        use_list ? "R6" : (rem1 > PG ? "R5" : "R4"),
                                        off, len, reads, exp_reads));
      chk(cmd_ready == 1'b1, $sformatf("R8 idle after command act=%0b exp=1", cmd_ready));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int offs[7] = '{0, 1, 7, 8, 31, 56, 63};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(cmd_ready && !seg_valid && !rd_req_valid && !err,
          $sformatf("R10 reset act=%0b%0b%0b%0b exp=1000", cmd_ready, seg_valid,
                    rd_req_valid, err));

      foreach (offs[i]) begin
         int off = offs[i];
         int cap = 10 * PG - off;
         // R4/R5/R6 boundaries around one and two pages after the first segment
         run_cmd(off, 1, 0);
         run_cmd(off, PG - off, 0);
         run_cmd(off, PG - off + 1, 0);
         run_cmd(off, 2 * PG - off, 0);
         run_cmd(off, 2 * PG - off + 1, 0);
         run_cmd(off, 3 * PG - off, 0);
         run_cmd(off, 3 * PG - off + 1, 0);
         run_cmd(off, cap, 0);
         for (int len = 2; len < cap; len += 11) run_cmd(off, len, 0);
      end

      // R7: corrupt each non-first position in turn
      run_cmd(5, 100, 1);
      run_cmd(0, 150, 2);
      run_cmd(9, 300, 1);
      run_cmd(9, 300, 2);
      run_cmd(9, 300, 3);
      run_cmd(0, 640, 6);
      run_cmd(0, 640, 9);
      run_cmd(0, 60, 1);     // R7: corrupt pointer unused, no error
      run_cmd(3, 130, 0);    // R7: block recovers after an error

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule